// File: doc/BRIEF.md
# Condition Code and Branch Evaluator

This block is the flag slice of a small 8-bit accumulator processor. Each clock it can accept one operation on the accumulator path: load a value, compare accumulator A with accumulator B, compare A with a memory operand, increment or decrement A, or shift A left arithmetically. It computes the operation's result and the new negative, zero, overflow and carry flags. When the operation is valid and writes flags, it stores them in a four-bit condition register on the clock edge.

The block also decides branches. A three-bit selector picks a branch condition, and a combinational output reports whether that branch would be taken, based on the flags that are currently stored. Equality, signed and unsigned conditions all come from the same flag set. The normal sequence is a compare in one cycle and the branch decision in the next cycle. The block has no accumulators of its own: the operands arrive on ports, and the caller writes back any result it needs.

Top module: `ccr_unit`

## Requirements
- R1: A synchronous reset clears all four flags to 0. The flag output packs them as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.
- R2: The flags keep their value on any edge where op_valid is 0, or where the op code is 0 (no operation) or 7 (unused). For these op codes the result output shows acc_a.
- R3: Load (op 1) presents mem_opnd as the result. It sets N from the top bit and sets Z when the value is zero. It clears V and keeps C.
- R4: Compare A with B (op 2) presents acc_a − acc_b modulo 256 as the result. It sets N and Z from that value, and sets C when acc_a < acc_b as unsigned values (borrow).
- R5: On both compares, V is set when the two operands differ in sign and the result's sign differs from acc_a's sign.
- R6: Compare with operand (op 3) behaves like op 2, with mem_opnd in place of acc_b.
- R7: Decrement (op 4) and increment (op 5) act on acc_a. They update N, Z and V and keep C. V is set only for 0x80→0x7F on decrement and for 0x7F→0x80 on increment.
- R8: Arithmetic left shift (op 6) presents acc_a doubled modulo 256. C receives the old top bit of acc_a, and V = N xor C.
- R9: Branch select 1 (equal) is taken when Z is 1. Select 2 (not equal) is taken when Z is 0.
- R10: Select 3 (signed less than) is taken when N xor V is 1. Select 4 (signed greater or equal) is its inverse.
- R11: Select 5 (unsigned higher or same) is taken when C is 0. Select 6 (unsigned lower) is taken when C is 1.
- R12: Select 0 is always taken. Select 7 (minus) is taken when N is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | The op code is valid this cycle |
| op | input | 3 | Operation code |
| acc_a | input | 8 | Accumulator A value |
| acc_b | input | 8 | Accumulator B value |
| mem_opnd | input | 8 | Memory operand (load source, compare operand) |
| br_sel | input | 3 | Branch condition selector |
| result | output | 8 | Combinational result of the current operation |
| flags | output | 4 | Stored flags {N,Z,V,C} |
| br_taken | output | 1 | Branch decision for br_sel from the stored flags |

## Verification
The compare cases pair operands that separate signed order from unsigned order: 0x7F against 0x86 is greater as signed but lower as unsigned. This shows whether the less-than and higher-or-same branches read V and C correctly. The increment and decrement operands sit on the 0x7F/0x80 sign boundary, and the shift operands have the top bit either set or clear. Loads run with C set beforehand, so a load that wrongly cleared C is caught. A long run of pseudo-random operations, with op_valid sometimes low, then compares the result, the flags and all eight branch conditions against a behavioural model on every cycle.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
   typedef enum logic [2:0] {
      OP_NOP    = 3'd0,
      OP_LOAD   = 3'd1,
      OP_CMP_AB = 3'd2,
      OP_CMP_M  = 3'd3,
      OP_DEC    = 3'd4,
      OP_INC    = 3'd5,
      OP_ASL    = 3'd6,
      OP_RSVD   = 3'd7
   } op_e;

   typedef enum logic [2:0] {
      BR_ALWAYS = 3'd0,
      BR_EQ     = 3'd1,
      BR_NE     = 3'd2,
      BR_LT     = 3'd3,
      BR_GE     = 3'd4,
      BR_HS     = 3'd5,
      BR_LO     = 3'd6,
      BR_MI     = 3'd7
   } br_sel_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } ccr_t;
endpackage

// File: rtl/ccr_alu.sv
module ccr_alu
   import ccr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] acc_a,
   input  logic [DATA_W-1:0] acc_b,
   input  logic [DATA_W-1:0] mem_opnd,
   input  ccr_t              cur,
   output logic [DATA_W-1:0] result,
   output ccr_t              nxt,
   output logic              writes
);
   localparam int MSB = DATA_W - 1;
   localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};

   logic [DATA_W-1:0] sub_src;
   logic [DATA_W-1:0] diff;
   logic              borrow;
   logic              sub_ovf;

   assign sub_src = (op == OP_CMP_M) ? mem_opnd : acc_b;
   assign {borrow, diff} = {1'b0, acc_a} - {1'b0, sub_src};
   assign sub_ovf = (acc_a[MSB] ^ sub_src[MSB]) & (diff[MSB] ^ acc_a[MSB]);

   always_comb begin
      result = acc_a;
      nxt    = cur;
      writes = 1'b1;
      unique case (op)
         OP_LOAD: begin
            result = mem_opnd;
            nxt.v  = 1'b0;
         end
         OP_CMP_AB, OP_CMP_M: begin
            result = diff;
            nxt.v  = sub_ovf;
            nxt.c  = borrow;
         end
         OP_DEC: begin
            result = acc_a - ONE;
            nxt.v  = (acc_a == SMIN);
         end
         OP_INC: begin
            result = acc_a + ONE;
            nxt.v  = (acc_a == SMAX);
         end
         OP_ASL: begin
            result = {acc_a[MSB-1:0], 1'b0};
            nxt.c  = acc_a[MSB];
            nxt.v  = acc_a[MSB] ^ acc_a[MSB-1];
         end
         default: writes = 1'b0;
      endcase
      if (writes) begin
         nxt.n = result[MSB];
         nxt.z = (result == '0);
      end
   end
endmodule

// File: rtl/ccr_branch.sv
module ccr_branch
   import ccr_pkg::*;
(
   input  ccr_t    f,
   input  br_sel_e sel,
   output logic    taken
);
   logic signed_lt;
   assign signed_lt = f.n ^ f.v;

   always_comb begin
      unique case (sel)
         BR_ALWAYS: taken = 1'b1;
         BR_EQ:     taken = f.z;
         BR_NE:     taken = !f.z;
         BR_LT:     taken = signed_lt;
         BR_GE:     taken = !signed_lt;
         BR_HS:     taken = !f.c;
         BR_LO:     taken = f.c;
         BR_MI:     taken = f.n;
         default:   taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/ccr_reg.sv
module ccr_reg
   import ccr_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic we,
   input  ccr_t d,
   output ccr_t q
);
   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (we) q <= d;
   end

   // R2: no write enable means the register holds its value
   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(q));
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
   import ccr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] acc_a,
   input  logic [DATA_W-1:0] acc_b,
   input  logic [DATA_W-1:0] mem_opnd,
   input  logic [2:0]        br_sel,
   output logic [DATA_W-1:0] result,
   output logic [3:0]        flags,
   output logic              br_taken
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_width_check
         $error("ccr_unit: DATA_W must be at least 2");
      end
   endgenerate

   op_e  op_q;
   ccr_t cur;
   ccr_t nxt;
   logic writes;

   assign op_q = op_e'(op);

   ccr_alu #(.DATA_W(DATA_W)) u_alu (
      .op       (op_q),
      .acc_a    (acc_a),
      .acc_b    (acc_b),
      .mem_opnd (mem_opnd),
      .cur      (cur),
      .result   (result),
      .nxt      (nxt),
      .writes   (writes)
   );

   ccr_reg u_reg (
      .clk (clk),
      .rst (rst),
      .we  (op_valid & writes),
      .d   (nxt),
      .q   (cur)
   );

   ccr_branch u_br (
      .f     (cur),
      .sel   (br_sel_e'(br_sel)),
      .taken (br_taken)
   );

   assign flags = cur;

   // R3: a load clears V and leaves C as it was
   assert_load_keeps_c_R3: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op == 3'd1) |=> (!flags[1] && flags[0] == $past(flags[0])));

   // R4: comparing equal values gives Z set and no borrow
   assert_cmp_equal_R4: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op == 3'd2 && acc_a == acc_b) |=> (flags[2] && !flags[0] && !flags[1]));

   // R7: increment and decrement keep C
   assert_incdec_keeps_c_R7: assert property (@(posedge clk) disable iff (rst)
      (op_valid && (op == 3'd4 || op == 3'd5)) |=> (flags[0] == $past(flags[0])));

   // R8: the shift moves the old top bit of A into C
   assert_asl_carry_R8: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op == 3'd6) |=> (flags[0] == $past(acc_a[MSB])));

   // R11: higher-or-same and lower are complementary on the stored flags
   assert_hs_vs_c_R11: assert property (@(posedge clk) disable iff (rst)
      (br_sel == 3'd5) |-> (br_taken != flags[0]));
endmodule

// File: tb/sim_ccr_unit.sv
module sim_ccr_unit;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst;
   logic       op_valid;
   logic [2:0] op;
   logic [7:0] acc_a, acc_b, mem_opnd;
   logic [2:0] br_sel;
   logic [7:0] result;
   logic [3:0] flags;
   logic       br_taken;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   bit en, ez, ev, ec;
   string flag_tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   ccr_unit u0 (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op(op),
      .acc_a(acc_a), .acc_b(acc_b), .mem_opnd(mem_opnd),
      .br_sel(br_sel), .result(result), .flags(flags), .br_taken(br_taken)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic bit br_model(input int sel);
      case (sel)
         0: return 1'b1;
         1: return ez;
         2: return !ez;
         3: return en ^ ev;
         4: return !(en ^ ev);
         5: return !ec;
         6: return ec;
         default: return en;
      endcase
   endfunction

   function automatic string br_tag(input int sel);
      case (sel)
         1, 2: return "R9";
         3, 4: return "R10";
         5, 6: return "R11";
         default: return "R12";
      endcase
   endfunction

   function automatic string op_tag(input int o);
      case (o)
         1: return "R3";
         2: return "R4 R5";
         3: return "R6 R5";
         4, 5: return "R7";
         6: return "R8";
         default: return "R2";
      endcase
   endfunction

   task automatic step(input int o, input int a, input int b, input int m,
                       input int sel, input bit vld);
      int r, src;
      bit nn, nz, nv, nc, wr;
      @(negedge clk);
      op_valid = vld; op = o[2:0]; acc_a = a[7:0]; acc_b = b[7:0];
      mem_opnd = m[7:0]; br_sel = sel[2:0];
      #1;
      nv = ev; nc = ec; wr = 1'b1;
      case (o)
         1: begin r = m; nv = 0; end
         2, 3: begin
            src = (o == 2) ? b : m;
            r = (a - src) & 255;
            nc = (a < src);
            nv = (((a ^ src) & (a ^ r) & 128) != 0);
         end
         4: begin r = (a - 1) & 255; nv = (a == 128); end
         5: begin r = (a + 1) & 255; nv = (a == 127); end
         6: begin r = (a << 1) & 255; nc = a[7]; nv = r[7] ^ a[7]; end
         default: begin r = a; wr = 1'b0; end
      endcase
      nn = r[7]; nz = (r == 0);
      check(result == r[7:0], op_tag(o), "result", result, r);
      check(flags == {en, ez, ev, ec}, flag_tag, "flags", flags, {en, ez, ev, ec});
      check(br_taken == br_model(sel), br_tag(sel), "branch", br_taken, br_model(sel));
      @(posedge clk);
      if (vld && wr) begin
         en = nn; ez = nz; ev = nv; ec = nc;
         flag_tag = op_tag(o);
      end else begin
         flag_tag = "R2";
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; op_valid = 1'b1; op = 3'd2; acc_a = 8'h00; acc_b = 8'h01;
      @(posedge clk); @(posedge clk);
      #1;
      check(flags == 4'h0, "R1", "flags in reset", flags, 0);
      @(negedge clk);
      rst = 1'b0; op_valid = 1'b0;
      en = 0; ez = 0; ev = 0; ec = 0; flag_tag = "R1";
   endtask

   initial begin
      rst = 1'b1; op_valid = 1'b0; op = 3'd0; acc_a = 8'h00; acc_b = 8'h00;
      mem_opnd = 8'h00; br_sel = 3'd0;
      do_reset();
      // R3: loading 0x7F with C set beforehand
      step(2, 8'h10, 8'h20, 0, 0, 1);        // borrow sets C (R4)
      step(1, 0, 0, 8'h7F, 6, 1);           // load 0x7F, LO reads C=1 (R11)
      step(0, 0, 0, 0, 7, 1);               // flags N=0 Z=0 V=0 C=1 (R3)
      step(1, 0, 0, 8'h00, 1, 1);           // load zero
      step(0, 0, 0, 0, 1, 1);               // EQ taken on Z (R9)
      // signed versus unsigned order: 0x7F vs 0x86 (R10, R11)
      step(2, 8'h7F, 8'h86, 0, 3, 1);
      step(0, 8'h7F, 8'h86, 0, 3, 1);       // LT not taken
      step(0, 0, 0, 0, 4, 1);               // GE taken
      step(0, 0, 0, 0, 5, 1);               // HS not taken (borrow)
      step(0, 0, 0, 0, 6, 1);               // LO taken
      // compare with operand, signed overflow 0x80 - 0x01 (R5, R6)
      step(3, 8'h80, 8'h00, 8'h01, 2, 1);
      step(0, 0, 0, 0, 3, 1);
      step(3, 8'h42, 8'h00, 8'h42, 0, 1);   // equal via operand
      step(0, 0, 0, 0, 1, 1);
      // increment/decrement at the sign boundary (R7)
      step(5, 8'h7F, 0, 0, 0, 1);
      step(4, 8'h80, 0, 0, 7, 1);
      step(5, 8'hFF, 0, 0, 2, 1);
      step(4, 8'h01, 0, 0, 1, 1);
      // shift (R8)
      step(6, 8'h40, 0, 0, 0, 1);
      step(6, 8'h81, 0, 0, 3, 1);
      step(6, 8'h80, 0, 0, 6, 1);
      step(0, 0, 0, 0, 1, 1);
      // R2: invalid and no-op cycles leave the flags alone
      step(2, 8'h05, 8'h05, 0, 0, 0);
      step(5, 8'h7F, 0, 0, 0, 0);
      step(7, 8'h00, 0, 0, 0, 1);
      step(0, 0, 0, 0, 1, 1);
      // R1: reset after flags were set
      step(2, 8'h00, 8'h01, 0, 0, 1);
      do_reset();
      step(0, 0, 0, 0, 6, 1);
      // mixed run against the model on every cycle
      for (int i = 0; i < 600; i++) begin
         step(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
              int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
              int'($urandom_range(0, 7)), ($urandom_range(0, 4) != 0));
      end
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule